// File: doc/BRIEF.md
# Frame-Clock Ratio Supervisor

This block runs on the master clock of an audio converter's serial port and decides how many master clocks make up one sample period. It measures the spacing between successive rising edges of the frame (left/right) clock. A spacing near 256 means the port runs 64 bit clocks per frame, and a spacing near 384 means 48 bit clocks per frame. Once a valid spacing has been measured, the block reports the ratio and holds it as a lock.

The same block decides when the converter datapath may be trusted. A low power-down input, any change on the serial-format, de-emphasis or speed selects, or a frame edge that drifts too far from where the lock predicts, sends the block back through a reinitialization. During reinitialization a soft reset stays asserted and the playback and capture words are forced to zero. Ready is raised only after a fixed number of further frames have passed under lock.

All control inputs and the frame clock are passed through two-flop synchronizers before use. The block has no software access. It is used by wiring its soft reset and ready to the converter datapath, and its bit count to the serial shifter.

Top module: `clk_ratio_supervisor`

## Requirements
- R1: A lock is declared on the second frame-clock rising edge after a restart when the spacing between those edges is within TOL (10) master clocks of 256 or of 384. A spacing near 256 gives `ratio_384`=0 and `frame_bits`=64. A spacing near 384 gives `ratio_384`=1 and `frame_bits`=48.
- R2: When the frame spacing is outside both windows, `locked` and `ready` stay low and `frame_bits` reads 0.
- R3: While locked, a frame edge that has not arrived within TOL clocks after its expected position, or that arrives off by more than TOL, drops `locked` and `ready`. A displacement of TOL or less has no effect.
- R4: Any change of `mode_sel`, `demph_sel` or `speed_sel` drops `locked` and `ready` and starts a new reinitialization.
- R5: While `pdn_n` is low, `locked` and `ready` stay low and `soft_rst` stays high. Reinitialization starts only after `pdn_n` returns high.
- R6: After a lock, `ready` rises within 8 master clocks of the 128th (SETTLE_FRAMES) further frame-clock rising edge, and not before that edge.
- R7: `soft_rst` is the inverse of `ready`. `play_out` and `cap_out` read zero while `ready` is low and equal `play_in` and `cap_in` while it is high.
- R8: `ratio_384` does not change for as long as `locked` stays high.
- R9: After `rst`, `ready` and `locked` are low, `soft_rst` is high and `frame_bits` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every register runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down request, active low |
| lrclk | input | 1 | Frame (left/right) clock |
| mode_sel | input | 3 | Serial format select |
| demph_sel | input | 2 | De-emphasis select |
| speed_sel | input | 1 | Sample-rate range select |
| play_in | input | DW | Playback word from the serial port |
| cap_in | input | DW | Capture word from the converter |
| ratio_384 | output | 1 | 1 when locked at 384 master clocks per frame |
| frame_bits | output | 7 | Bit clocks per frame (48 or 64), 0 when unlocked |
| locked | output | 1 | Frame spacing is measured and valid |
| ready | output | 1 | Reinitialization complete, data valid |
| soft_rst | output | 1 | Datapath reset, high while not ready |
| play_out | output | DW | Gated playback word |
| cap_out | output | DW | Gated capture word |

## Verification
The assertions assume that the frame clock and the selects are synchronous to the master clock and that each level is held for at least several master clocks. This lets the two-flop synchronizers show every change, and a power-down held for three cycles is then visible in the state. The stimulus drives every input on the falling clock edge. It keeps each frame-clock phase tens of clocks long, moves a single edge only by whole cycles, and holds power-down and the selects steady for long stretches between changes. Frame spacing is chosen at the two valid ratios, at displacements just inside and well outside the tolerance, and at a value between the two windows.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        ST_PDOWN,
        ST_ACQ,
        ST_SETTLE,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        RC_NONE,
        RC_256,
        RC_384
    } ratio_class_e;

    localparam int unsigned PERIOD_LO = 256;
    localparam int unsigned PERIOD_HI = 384;
    localparam int unsigned BITS_LO   = 64;
    localparam int unsigned BITS_HI   = 48;
    localparam int unsigned FB_W      = $clog2(BITS_LO + 1);

    function automatic logic near(input int unsigned val, input int unsigned ref_v,
                                  input int unsigned tol);
        return (val + tol >= ref_v) && (val <= ref_v + tol);
    endfunction

    function automatic ratio_class_e classify(input int unsigned period,
                                              input int unsigned tol);
        if (near(period, PERIOD_LO, tol))
            return RC_256;
        if (near(period, PERIOD_HI, tol))
            return RC_384;
        return RC_NONE;
    endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/crs_ratio_det.sv
module crs_ratio_det
    import crs_pkg::*;
#(
    parameter int unsigned TOL   = 10,
    parameter int unsigned CNT_W = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lr_s,
    output logic locked,
    output logic is_384,
    output logic slip,
    output logic frame_edge
);
    logic             lr_q;
    logic             have_edge;
    logic             locked_q;
    logic             r384_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nominal;
    ratio_class_e     cls;
    ratio_class_e     held_cls;

    always_comb begin
        frame_edge = lr_s & ~lr_q;
        cls        = classify(32'(cnt), TOL);
        held_cls   = r384_q ? RC_384 : RC_256;
        nominal    = r384_q ? CNT_W'(PERIOD_HI) : CNT_W'(PERIOD_LO);
        if (!locked_q)
            slip = 1'b0;
        else if (frame_edge)
            slip = (cls != held_cls);
        else
            slip = (cnt == nominal + CNT_W'(TOL));
    end

    always_ff @(posedge clk) begin
        if (rst) lr_q <= 1'b0;
        else     lr_q <= lr_s;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_edge <= 1'b0;
            locked_q  <= 1'b0;
            r384_q    <= 1'b0;
            cnt       <= '0;
        end else begin
            if (frame_edge)
                cnt <= CNT_W'(1);
            else if (cnt != '1)
                cnt <= cnt + CNT_W'(1);

            if (frame_edge)
                have_edge <= 1'b1;
            else if (slip)
                have_edge <= 1'b0;

            if (slip) begin
                locked_q <= 1'b0;
            end else if (frame_edge && have_edge && !locked_q && cls != RC_NONE) begin
                locked_q <= 1'b1;
                r384_q   <= (cls == RC_384);
            end
        end
    end

    assign locked = locked_q;
    assign is_384 = r384_q;
endmodule

// File: rtl/crs_reinit_seq.sv
module crs_reinit_seq
    import crs_pkg::*;
#(
    parameter int unsigned SETTLE_FRAMES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_s,
    input  logic change,
    input  logic slip,
    input  logic locked,
    input  logic frame_edge,
    output logic ready
);
    localparam int unsigned SC_W = $clog2(SETTLE_FRAMES + 1);

    seq_state_e      st;
    logic [SC_W-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_PDOWN;
            scnt <= '0;
        end else if (!pdn_s) begin
            st   <= ST_PDOWN;
            scnt <= '0;
        end else if (change || slip) begin
            st   <= ST_ACQ;
            scnt <= '0;
        end else begin
            case (st)
                ST_PDOWN: st <= ST_ACQ;
                ST_ACQ: begin
                    if (locked) begin
                        st   <= ST_SETTLE;
                        scnt <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (!locked)
                        st <= ST_ACQ;
                    else if (frame_edge) begin
                        if (scnt == SC_W'(SETTLE_FRAMES - 1))
                            st <= ST_RUN;
                        else
                            scnt <= scnt + SC_W'(1);
                    end
                end
                default: begin
                    if (!locked)
                        st <= ST_ACQ;
                end
            endcase
        end
    end

    assign ready = (st == ST_RUN);
endmodule

// File: rtl/clk_ratio_supervisor.sv
module clk_ratio_supervisor
    import crs_pkg::*;
#(
    parameter int unsigned DW            = 24,
    parameter int unsigned TOL           = 10,
    parameter int unsigned SETTLE_FRAMES = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pdn_n,
    input  logic                   lrclk,
    input  logic [2:0]             mode_sel,
    input  logic [1:0]             demph_sel,
    input  logic                   speed_sel,
    input  logic [DW-1:0]          play_in,
    input  logic [DW-1:0]          cap_in,
    output logic                   ratio_384,
    output logic [FB_W-1:0]        frame_bits,
    output logic                   locked,
    output logic                   ready,
    output logic                   soft_rst,
    output logic [DW-1:0]          play_out,
    output logic [DW-1:0]          cap_out
);
    localparam int unsigned CTRL_W = 7;
    localparam int unsigned CNT_W  = $clog2(PERIOD_HI + TOL + 2);

    logic [CTRL_W:0]   raw_in;
    logic [CTRL_W:0]   sync_in;
    logic [CTRL_W-1:0] ctrl_q;
    logic              pdn_s;
    logic              lr_s;
    logic              change;
    logic              det_locked;
    logic              det_384;
    logic              slip;
    logic              frame_edge;
    logic              seq_ready;

    assign raw_in = {lrclk, pdn_n, speed_sel, demph_sel, mode_sel};

    crs_sync #(.W(CTRL_W + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    assign lr_s  = sync_in[CTRL_W];
    assign pdn_s = sync_in[CTRL_W-1];

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= sync_in[CTRL_W-1:0];
    end

    assign change = (sync_in[CTRL_W-1:0] != ctrl_q);

    crs_ratio_det #(.TOL(TOL), .CNT_W(CNT_W)) u_det (
        .clk        (clk),
        .rst        (rst),
        .clr        (change | ~pdn_s),
        .lr_s       (lr_s),
        .locked     (det_locked),
        .is_384     (det_384),
        .slip       (slip),
        .frame_edge (frame_edge)
    );

    crs_reinit_seq #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pdn_s      (pdn_s),
        .change     (change),
        .slip       (slip),
        .locked     (det_locked),
        .frame_edge (frame_edge),
        .ready      (seq_ready)
    );

    always_comb begin
        locked     = det_locked;
        ratio_384  = det_locked & det_384;
        if (!det_locked)
            frame_bits = '0;
        else if (det_384)
            frame_bits = FB_W'(BITS_HI);
        else
            frame_bits = FB_W'(BITS_LO);
        ready    = seq_ready;
        soft_rst = ~seq_ready;
        play_out = seq_ready ? play_in : '0;
        cap_out  = seq_ready ? cap_in  : '0;
    end
endmodule

// File: rtl/crs_checker.sv
module crs_checker
    import crs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pdn_n,
    input logic            locked,
    input logic            ready,
    input logic            ratio_384,
    input logic [FB_W-1:0] frame_bits
);
    // R6: data is never declared valid without a lock
    a_r6_ready_needs_lock: assert property (@(posedge clk) disable iff (rst)
        ready |-> locked);

    // R6: a fresh lock always goes through the settling window first
    a_r6_lock_before_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> !ready);

    // R3: losing lock takes ready down in the same cycle
    a_r3_unlock_drops_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> !ready);

    // R5: a held power-down keeps the block idle
    a_r5_pdown_idle: assert property (@(posedge clk) disable iff (rst)
        (!pdn_n && $past(!pdn_n) && $past(!pdn_n, 2) && $past(!pdn_n, 3))
        |-> (!ready && !locked));

    // R8: ratio is held for the whole lock
    a_r8_ratio_held: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(ratio_384));

    // R1: a ready datapath always has a bit count
    a_r1_ready_has_bits: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (frame_bits != '0));
endmodule

bind clk_ratio_supervisor crs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pdn_n      (pdn_n),
    .locked     (locked),
    .ready      (ready),
    .ratio_384  (ratio_384),
    .frame_bits (frame_bits)
);

// File: tb/clk_ratio_supervisor_tb.sv
`timescale 1ns/1ps
module clk_ratio_supervisor_tb;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pdn_n = 1'b0;
    logic          lrclk;
    logic [2:0]    mode_sel = 3'd0;
    logic [1:0]    demph_sel = 2'd3;
    logic          speed_sel = 1'b0;
    logic [DW-1:0] play_in = 24'hA5C3E1;
    logic [DW-1:0] cap_in  = 24'h123456;
    logic          ratio_384;
    logic [6:0]    frame_bits;
    logic          locked;
    logic          ready;
    logic          soft_rst;
    logic [DW-1:0] play_out;
    logic [DW-1:0] cap_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int gen_on = 0;
    int period = 256;
    int shift  = 0;
    int n_edges = 0;

    always #2.5 clk = ~clk;

    clk_ratio_supervisor u_dut (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .lrclk(lrclk),
        .mode_sel(mode_sel), .demph_sel(demph_sel), .speed_sel(speed_sel),
        .play_in(play_in), .cap_in(cap_in),
        .ratio_384(ratio_384), .frame_bits(frame_bits), .locked(locked),
        .ready(ready), .soft_rst(soft_rst), .play_out(play_out), .cap_out(cap_out)
    );

    initial begin
        lrclk = 1'b0;
        forever begin
            if (gen_on == 0) begin
                lrclk = 1'b0;
                @(negedge clk);
            end else begin
                lrclk = 1'b1;
                n_edges++;
                repeat (period / 2) @(negedge clk);
                lrclk = 1'b0;
                repeat (period - period / 2 + shift) @(negedge clk);
                shift = 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_lock();
        for (int i = 0; i < 4000 && !locked; i++) @(negedge clk);
    endtask

    task automatic wait_edges(input int target);
        while (n_edges < target) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_cycles(10);
        rst = 1'b0;
        wait_cycles(2);
        check("R9 ready", ready, 0);
        check("R9 locked", locked, 0);
        check("R9 soft_rst", soft_rst, 1);
        check("R9 frame_bits", frame_bits, 0);
    endtask

    task automatic t_pdown();
        gen_on = 1;
        wait_cycles(2000);
        check("R5 locked in power-down", locked, 0);
        check("R5 ready in power-down", ready, 0);
        check("R5 soft_rst in power-down", soft_rst, 1);
    endtask

    task automatic t_settle_256();
        int e0;
        pdn_n = 1'b1;
        wait_lock();
        e0 = n_edges;
        check("R1 lock at 256", locked, 1);
        check("R1 ratio at 256", ratio_384, 0);
        check("R1 bits at 256", frame_bits, 64);
        check("R7 play zero while settling", play_out, 0);
        check("R7 cap zero while settling", cap_out, 0);
        wait_edges(e0 + 127);
        wait_cycles(20);
        check("R6 ready before last settle edge", ready, 0);
        wait_edges(e0 + 128);
        wait_cycles(10);
        check("R6 ready after settle", ready, 1);
        check("R7 soft_rst when ready", soft_rst, 0);
        check("R7 play passes", play_out, play_in);
        check("R7 cap passes", cap_out, cap_in);
    endtask

    task automatic t_jitter();
        int e;
        e = n_edges;
        wait_edges(e + 1);
        wait_cycles(4);
        shift = 5;
        wait_edges(e + 4);
        wait_cycles(4);
        shift = -5;
        wait_edges(e + 7);
        wait_cycles(4);
        check("R3 small shift keeps lock", locked, 1);
        check("R3 small shift keeps ready", ready, 1);
    endtask

    task automatic t_slip();
        int e;
        e = n_edges;
        wait_edges(e + 1);
        wait_cycles(4);
        shift = 20;
        wait_edges(e + 2);
        wait_cycles(5);
        check("R3 slip drops lock", locked, 0);
        check("R3 slip drops ready", ready, 0);
        wait_lock();
        check("R3 relock after slip", locked, 1);
    endtask

    task automatic t_ctrl_change();
        mode_sel = 3'd5;
        wait_cycles(8);
        check("R4 mode change drops lock", locked, 0);
        wait_lock();
        check("R4 relock after mode change", locked, 1);
        speed_sel = 1'b1;
        wait_cycles(8);
        check("R4 speed change drops lock", locked, 0);
        check("R4 speed change ready low", ready, 0);
    endtask

    task automatic t_bad_ratio();
        period = 330;
        wait_cycles(3000);
        check("R2 no lock at 330", locked, 0);
        check("R2 no bits at 330", frame_bits, 0);
        check("R2 no ready at 330", ready, 0);
    endtask

    task automatic t_settle_384();
        period = 384;
        wait_lock();
        check("R1 lock at 384", locked, 1);
        check("R1 ratio at 384", ratio_384, 1);
        check("R1 bits at 384", frame_bits, 48);
        wait_cycles(3000);
        check("R8 ratio held while locked", ratio_384, 1);
        for (int i = 0; i < 60000 && !ready; i++) @(negedge clk);
        check("R6 ready at 384", ready, 1);
        demph_sel = 2'd1;
        wait_cycles(8);
        check("R4 de-emphasis change drops ready", ready, 0);
        check("R4 de-emphasis change drops lock", locked, 0);
        check("R7 play zero after change", play_out, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pdown();
        t_settle_256();
        t_jitter();
        t_slip();
        t_ctrl_change();
        t_bad_ratio();
        t_settle_384();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule